// File: doc/BRIEF.md
# Over-Temperature Stage Alarm

This block watches a digital die-temperature sample, given in millidegrees Celsius, and classifies it into one of four over-temperature stages. Stage 0 means the die is cooler than the lowest trip point. Stages 1, 2 and 3 mean that the first, second or third trip point has been reached. The three trip points are 20 °C apart. A 2-bit threshold setting moves all three together in 5 °C steps, starting from 105 °C. To climb into a stage, the sample must reach that stage's trip point. To leave a stage downward, the sample must fall more than 2 °C below it. Each time the stage value changes, the block emits an interrupt pulse that lasts one clock.

Software reaches the block through a byte-wide synchronous register port. Writes take effect on the clock edge. Reads are combinational from the address. The map holds two fixed identification bytes, a read-only status byte that carries the stage, a threshold register, and an alarm control register whose top bit keeps the alarm running. While that bit is clear, the stage is held at 0 and no interrupt is produced. One shutdown-request line per stage is also provided, set whenever the stage is at or above that stage. These lines only report the request; they do not act on anything.

Top module: `ot_stage_alarm`

## Requirements
- R1: A read at offset 0x04 returns 0x09 and a read at offset 0x05 returns 0x08.
- R2: A read at offset 0x08 returns the current stage in bits [1:0], with bits [7:2] zero.
- R3: Offset 0x40 holds the threshold select in bits [1:0] and reads it back. The trip point of stage s (1..3) is 105000 + 5000·threshold + 20000·(s−1) millidegrees.
- R4: When a valid sample is at or above the trip point of a stage higher than the current one, the stage becomes the highest such stage on the next clock edge.
- R5: Bit 7 of offset 0x46 is the alarm enable and reads back in bit 7, with other bits zero. While it is 0, the stage becomes 0 on the next edge and `irq_pulse` stays low.
- R6: `irq_pulse` is high for exactly the one cycle in which a new stage value first appears, in either direction. It stays low when an evaluation leaves the stage unchanged.
- R7: A stage s ≥ 1 is left downward only when a valid sample is below its trip point minus 2000. A sample equal to trip − 2000 keeps the stage.
- R8: A sample may move the stage by more than one step in a single update. Such a jump produces exactly one interrupt pulse.
- R9: After reset, the threshold is 0, the enable is 0, the stage is 0 and `irq_pulse` is 0. A read of an unmapped offset returns 0x00.
- R10: Writes to offsets 0x04, 0x05 and 0x08 are ignored.
- R11: The stage is evaluated only in cycles where `temp_vld` is high. A sample presented with `temp_vld` low has no effect.
- R12: `shdn_req[k]` (k = 0..2) is high exactly when the stage is at least k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from `reg_addr` |
| temp_mc | input | 32 | Signed die temperature in millidegrees Celsius |
| temp_vld | input | 1 | Qualifies `temp_mc` for evaluation |
| stage | output | 2 | Current over-temperature stage |
| irq_pulse | output | 1 | One-cycle pulse on a stage change |
| shdn_req | output | 3 | Per-stage shutdown request, thermometer coded |

## Verification
A wrong stage register shows at the status read, on the `stage` pins and on `shdn_req` one cycle after the sample that caused it. The missing or extra interrupt appears in that same cycle. Hysteresis faults only show on the way down, so the bench walks down to the exact trip − 2000 boundary and then one millidegree below it. A stuck enable or threshold bit shows at its readback at once, and at the next sample as a stage that is off by one trip step.

// File: rtl/ot_alarm_pkg.sv
package ot_alarm_pkg;
  localparam int OT_STAGES  = 3;
  localparam int OT_STAGE_W = $clog2(OT_STAGES + 1);
  localparam int OT_THR_W   = 2;

  localparam logic [7:0] OFS_TYPE   = 8'h04;
  localparam logic [7:0] OFS_SUBTP  = 8'h05;
  localparam logic [7:0] OFS_STATUS = 8'h08;
  localparam logic [7:0] OFS_THRESH = 8'h40;
  localparam logic [7:0] OFS_ALARM  = 8'h46;
  localparam logic [7:0] ID_TYPE    = 8'h09;
  localparam logic [7:0] ID_SUBTYPE = 8'h08;
  localparam int         ALARM_EN_BIT = 7;

  // Trip point of stage s (1-based) in millidegrees.
  function automatic int trip_point(int base, int tstep, int sstep,
                                    logic [OT_THR_W-1:0] thr, int s);
    return base + tstep * int'(thr) + sstep * (s - 1);
  endfunction

  function automatic logic [OT_STAGE_W-1:0] count_set(logic [OT_STAGES-1:0] v);
    logic [OT_STAGE_W-1:0] n;
    n = '0;
    for (int i = 0; i < OT_STAGES; i++) n = n + OT_STAGE_W'(v[i]);
    return n;
  endfunction

  // Climb to the reached stage, else fall only as far as hysteresis allows.
  function automatic logic [OT_STAGE_W-1:0] next_stage(logic [OT_STAGES-1:0] reach,
                                                       logic [OT_STAGES-1:0] keep,
                                                       logic [OT_STAGE_W-1:0] cur);
    logic [OT_STAGE_W-1:0] up, hold;
    up   = count_set(reach);
    hold = count_set(keep);
    if (up > cur) return up;
    return (hold < cur) ? hold : cur;
  endfunction
endpackage

// File: rtl/ot_alarm_regs.sv
module ot_alarm_regs
  import ot_alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [7:0]            addr,
  input  logic [7:0]            wdata,
  input  logic [OT_STAGE_W-1:0] stage_i,
  output logic [7:0]            rdata,
  output logic [OT_THR_W-1:0]   thr_o,
  output logic                  en_o
);
  logic [OT_THR_W-1:0] thr_q;
  logic                en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
      en_q  <= 1'b0;
    end else if (wr_en) begin
      if (addr == OFS_THRESH) thr_q <= wdata[OT_THR_W-1:0];
      if (addr == OFS_ALARM)  en_q  <= wdata[ALARM_EN_BIT];
    end
  end

  always_comb begin
    rdata = 8'h00;
    case (addr)
      OFS_TYPE:   rdata = ID_TYPE;
      OFS_SUBTP:  rdata = ID_SUBTYPE;
      OFS_STATUS: rdata = {{(8-OT_STAGE_W){1'b0}}, stage_i};
      OFS_THRESH: rdata = {{(8-OT_THR_W){1'b0}}, thr_q};
      OFS_ALARM:  rdata = 8'(en_q) << ALARM_EN_BIT;
      default:    rdata = 8'h00;
    endcase
  end

  assign thr_o = thr_q;
  assign en_o  = en_q;
endmodule

// File: rtl/ot_alarm_stage.sv
module ot_alarm_stage
  import ot_alarm_pkg::*;
#(
  parameter int TEMP_W        = 32,
  parameter int BASE_MC       = 105000,
  parameter int THR_STEP_MC   = 5000,
  parameter int STAGE_STEP_MC = 20000,
  parameter int HYST_MC       = 2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en_i,
  input  logic [OT_THR_W-1:0]      thr_i,
  input  logic signed [TEMP_W-1:0] temp_i,
  input  logic                     vld_i,
  output logic [OT_STAGE_W-1:0]    stage_o,
  output logic                     irq_o,
  output logic [OT_STAGES-1:0]     shdn_o,
  output logic [OT_STAGE_W-1:0]    stage_nxt_o,
  output logic                     change_o
);
  logic [OT_STAGES-1:0]  reach, keep;
  logic [OT_STAGE_W-1:0] stage_q, stage_nxt;
  logic                  irq_q;

  for (genvar s = 1; s <= OT_STAGES; s++) begin : g_trip
    logic signed [TEMP_W-1:0] trip_v, keep_v;
    assign trip_v = TEMP_W'(trip_point(BASE_MC, THR_STEP_MC, STAGE_STEP_MC, thr_i, s));
    assign keep_v = trip_v - TEMP_W'(HYST_MC);
    assign reach[s-1]  = (temp_i >= trip_v);
    assign keep[s-1]   = (temp_i >= keep_v);
    assign shdn_o[s-1] = (stage_q >= OT_STAGE_W'(s));
  end

  assign stage_nxt = next_stage(reach, keep, stage_q);
  assign change_o  = en_i && vld_i && (stage_nxt != stage_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      irq_q   <= 1'b0;
    end else if (!en_i) begin
      stage_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      irq_q <= change_o;
      if (vld_i) stage_q <= stage_nxt;
    end
  end

  assign stage_o     = stage_q;
  assign irq_o       = irq_q;
  assign stage_nxt_o = stage_nxt;
endmodule

// File: rtl/ot_stage_alarm.sv
module ot_stage_alarm
  import ot_alarm_pkg::*;
#(
  parameter int BASE_MC       = 105000,
  parameter int THR_STEP_MC   = 5000,
  parameter int STAGE_STEP_MC = 20000,
  parameter int HYST_MC       = 2000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [7:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic [31:0] temp_mc,
  input  logic        temp_vld,
  output logic [1:0]  stage,
  output logic        irq_pulse,
  output logic [2:0]  shdn_req
);
  logic [OT_THR_W-1:0]   thr_w;
  logic                  alarm_en_w;
  logic [OT_STAGE_W-1:0] stage_w, stage_nxt_w;
  logic                  change_w;

  ot_alarm_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .stage_i(stage_w), .rdata(reg_rdata),
    .thr_o(thr_w), .en_o(alarm_en_w)
  );

  ot_alarm_stage #(
    .TEMP_W(32), .BASE_MC(BASE_MC), .THR_STEP_MC(THR_STEP_MC),
    .STAGE_STEP_MC(STAGE_STEP_MC), .HYST_MC(HYST_MC)
  ) u_stage (
    .clk(clk), .rst_n(rst_n), .en_i(alarm_en_w), .thr_i(thr_w),
    .temp_i($signed(temp_mc)), .vld_i(temp_vld), .stage_o(stage_w),
    .irq_o(irq_pulse), .shdn_o(shdn_req), .stage_nxt_o(stage_nxt_w),
    .change_o(change_w)
  );

  assign stage = stage_w;
endmodule

// File: rtl/ot_alarm_chk.sv
module ot_alarm_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       alarm_en,
  input logic       temp_vld,
  input logic       irq_pulse,
  input logic [1:0] stage,
  input logic [7:0] reg_addr,
  input logic [7:0] reg_rdata,
  input logic [2:0] shdn_req
);
  // R6
  irq_means_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_pulse |-> (stage != $past(stage)));

  // R6
  change_means_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((stage != $past(stage)) && $past(alarm_en)) |-> irq_pulse);

  // R5
  disabled_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !alarm_en |=> (stage == 2'd0 && !irq_pulse));

  // R11
  no_sample_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_en && !temp_vld) |=> $stable(stage));

  // R2
  status_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == 8'h08) |-> (reg_rdata == {6'b0, stage}));

  // R12
  shdn_thermo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(shdn_req) == int'(stage)) && (shdn_req[2] -> shdn_req[1])
      && (shdn_req[1] -> shdn_req[0]));
endmodule

bind ot_stage_alarm ot_alarm_chk u_chk (
  .clk(clk), .rst_n(rst_n), .alarm_en(alarm_en_w), .temp_vld(temp_vld),
  .irq_pulse(irq_pulse), .stage(stage), .reg_addr(reg_addr),
  .reg_rdata(reg_rdata), .shdn_req(shdn_req)
);

// File: tb/ot_stage_alarm_tb.sv
module ot_stage_alarm_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [7:0]  reg_wdata = 8'h00;
  logic [7:0]  reg_rdata;
  logic [31:0] temp_mc = 32'd0;
  logic        temp_vld = 1'b0;
  logic [1:0]  stage;
  logic        irq_pulse;
  logic [2:0]  shdn_req;

  int n_cmp = 0;
  int n_bad = 0;
  int m_stage = 0;
  int m_thr = 0;
  int m_en = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ot_stage_alarm u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .temp_mc(temp_mc),
    .temp_vld(temp_vld), .stage(stage), .irq_pulse(irq_pulse),
    .shdn_req(shdn_req)
  );

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output int d);
    reg_addr = a;
    #2;
    d = int'(reg_rdata);
  endtask

  function automatic int trip(int thr, int s);
    return 105000 + 5000 * thr + 20000 * (s - 1);
  endfunction

  function automatic int model(int t);
    int n;
    if (m_en == 0) return 0;
    n = m_stage;
    while (n < 3 && t >= trip(m_thr, n + 1)) n++;
    if (n == m_stage)
      while (n > 0 && t < trip(m_thr, n) - 2000) n--;
    return n;
  endfunction

  task automatic step(string req, int t);
    int exp;
    exp = model(t);
    @(negedge clk);
    temp_mc = t; temp_vld = 1'b1;
    @(negedge clk);
    temp_vld = 1'b0;
    chk({req, " stage"}, int'(stage), exp);
    chk({req, " irq"}, int'(irq_pulse), (exp != m_stage) ? 1 : 0);
    m_stage = exp;
    @(negedge clk);
    chk({req, " irq drop"}, int'(irq_pulse), 0);
  endtask

  task automatic t_reset();
    int d;
    chk("R9 stage", int'(stage), 0);
    chk("R9 irq", int'(irq_pulse), 0);
    rd(8'h04, d); chk("R1 type", d, 9);
    rd(8'h05, d); chk("R1 subtype", d, 8);
    rd(8'h08, d); chk("R9 status", d, 0);
    rd(8'h40, d); chk("R9 thresh", d, 0);
    rd(8'h46, d); chk("R9 enable", d, 0);
    rd(8'h10, d); chk("R9 unmapped", d, 0);
  endtask

  task automatic t_disabled();
    step("R5 disabled hot", 200000);
    chk("R5 disabled stage", int'(stage), 0);
  endtask

  task automatic t_climb_fall();
    int d;
    wr(8'h46, 8'h80); m_en = 1;
    rd(8'h46, d); chk("R5 enable readback", d, 8'h80);
    step("R4 below", 100000);
    step("R4 at trip1", 105000);
    step("R6 same stage", 124999);
    rd(8'h08, d); chk("R2 status", d, 1);
    step("R8 jump", 145000);
    chk("R12 shdn3", int'(shdn_req), 7);
    step("R7 at keep edge", 143000);
    step("R7 below keep", 142999);
    chk("R12 shdn2", int'(shdn_req), 3);
    step("R8 fall jump", 30000);
    chk("R12 shdn0", int'(shdn_req), 0);
  endtask

  task automatic t_thresh();
    int d;
    wr(8'h40, 8'h03); m_thr = 3;
    rd(8'h40, d); chk("R3 readback", d, 3);
    step("R3 below thr3", 119999);
    step("R3 at thr3", 120000);
    step("R3 top", 160000);
    step("R7 hold", 158000);
  endtask

  task automatic t_readonly();
    int d;
    wr(8'h04, 8'hFF);
    rd(8'h04, d); chk("R10 type kept", d, 9);
    wr(8'h05, 8'h00);
    rd(8'h05, d); chk("R10 subtype kept", d, 8);
    wr(8'h08, 8'h00);
    rd(8'h08, d); chk("R10 status kept", d, m_stage);
  endtask

  task automatic t_novalid();
    @(negedge clk);
    temp_mc = 0;
    repeat (3) @(negedge clk);
    chk("R11 no sample", int'(stage), m_stage);
    chk("R11 no irq", int'(irq_pulse), 0);
  endtask

  task automatic t_disable_hot();
    int d;
    wr(8'h46, 8'h00); m_en = 0;
    @(negedge clk);
    chk("R5 cleared", int'(stage), 0);
    chk("R5 no irq", int'(irq_pulse), 0);
    rd(8'h08, d); chk("R5 status", d, 0);
    m_stage = 0;
  endtask

  initial begin
    #(20 * 100000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_disabled();
    t_climb_fall();
    t_thresh();
    t_readonly();
    t_novalid();
    t_disable_hot();
    finish_run();
  end
endmodule